// File: doc/BRIEF.md
# Power-Down Input/Output Hold Controller

This block sits between a device's pins and its internal logic. It provides an optional low-power hold mode that one level-sensitive power-down input controls. A configuration bit arms the feature. While the feature is armed and the power-down input is high, the block freezes three things: the values the logic sees on the dedicated inputs (clock, clear and enable pins), the values it sees on the bidirectional pad inputs, and the output data and output-enable state at the pads. The internal register clock enable is dropped, so no register changes state.

When power-down ends, the live paths return at once. A status flag stays low for a parameterised number of timer-clock cycles so that the surrounding system knows when outputs are trustworthy again. If power-down returns during that window, the window restarts. While the feature is armed, the pad that carries the power-down input is removed from the logic inputs and its output driver is kept off. When the feature is not armed, that pad is an ordinary input/output and nothing is held.

Top module: `pdn_hold_ctrl`

## Requirements
- R1: During and directly after reset, `pd_active` is 0, `core_ce` is 1 and `out_valid` is 1.
- R2: `pd_active` is 1 exactly when `cfg_pd_en` and `pd_pin` are both 1, in the same cycle, and `core_ce` is always its inverse.
- R3: With `cfg_pd_en` = 0, every path passes through in the same cycle whatever `pd_pin` does: `ded_q` = `ded_in`, `io_in_q` = `pad_in`, `pad_out` = `core_out`, `pad_oe` = `core_oe`, including bit `PD_IDX`.
- R4: While `pd_active` is 1, `ded_q` and `io_in_q` keep the values sampled at the last rising clock edge before activation, and any change on `ded_in` or `pad_in` has no effect on them.
- R5: While `pd_active` is 1, `pad_out` and `pad_oe` keep the values sampled at the last rising clock edge before activation, and any change on `core_out` or `core_oe` has no effect on them.
- R6: A pad whose `pad_oe` bit was 0 (high impedance) when power-down began keeps `pad_oe` 0 for the whole power-down period, even if `core_oe` for that bit goes to 1.
- R7: With `cfg_pd_en` = 1, `io_in_q[PD_IDX]` reads 0 and `pad_oe[PD_IDX]` is 0 at all times. The other bits pass or hold as in R4 and R5.
- R8: `out_valid` is 0 while `pd_active` is 1. After `pd_active` falls it stays 0 through the first `RECOV_CYCLES`-1 rising edges and becomes 1 after edge number `RECOV_CYCLES`.
- R9: If `pd_active` rises again before the recovery count has expired, the count restarts from zero at the next release, so `out_valid` again needs the full `RECOV_CYCLES` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timer clock; hold registers and recovery counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pd_en | input | 1 | Configuration bit arming the power-down feature |
| pd_pin | input | 1 | Power-down request, active high |
| ded_in | input | N_DED | Dedicated input pins (clock, clear, enables) |
| pad_in | input | N_IO | Receive side of the bidirectional pads |
| core_out | input | N_IO | Output data from the internal logic |
| core_oe | input | N_IO | Output enables from the internal logic, 1 = drive |
| ded_q | output | N_DED | Dedicated inputs as seen by the logic |
| io_in_q | output | N_IO | Pad inputs as seen by the logic |
| pad_out | output | N_IO | Output data to the pad drivers |
| pad_oe | output | N_IO | Output enables to the pad drivers, 1 = drive |
| core_ce | output | 1 | Clock enable for every internal register |
| pd_active | output | 1 | Power-down currently in force |
| out_valid | output | 1 | Outputs valid: not powered down and recovery complete |

## Verification
The hold checks assume that `cfg_pd_en` is static while power-down is in force or recovering. They also assume that `ded_in`, `pad_in`, `core_out` and `core_oe` have been stable across at least one rising edge before `pd_pin` rises, because that edge is the one that captures the held values. The stimulus changes its data only at the instant after a clock edge. It always lets a full edge pass between the last data change and the rise of `pd_pin`, and it changes `cfg_pd_en` only while power-down is off and recovery has completed. Once power-down is in force, the stimulus deliberately drives new, inverted values on every input so that any leak through the hold is visible at the ports.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

   // Recovery sequencer states
   typedef enum logic [1:0] {
      PDN_IDLE    = 2'd0,
      PDN_DOWN    = 2'd1,
      PDN_RECOVER = 2'd2
   } pdn_state_e;

   // Width of a counter that must reach a value of n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/pdn_ctrl.sv
module pdn_ctrl #(
   parameter int unsigned RECOV_CYCLES = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_pd_en,
   input  logic pd_pin,
   output logic pd_active,
   output logic core_ce,
   output logic out_valid
);
   import pdn_pkg::*;

   localparam int unsigned CW = cnt_width(RECOV_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(RECOV_CYCLES - 1);

   generate
      if (RECOV_CYCLES < 1) begin : g_bad_recov
         $error("pdn_ctrl: RECOV_CYCLES must be at least 1");
      end
   endgenerate

   pdn_state_e       state;
   logic [CW-1:0]    cnt;

   // level-sensitive request, gated by the arming bit
   assign pd_active = cfg_pd_en & pd_pin;
   assign core_ce   = ~pd_active;
   assign out_valid = (state == PDN_IDLE) & ~pd_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PDN_IDLE;
         cnt   <= '0;
      end else if (pd_active) begin
         state <= PDN_DOWN;
         cnt   <= '0;
      end else begin
         unique case (state)
            PDN_DOWN, PDN_RECOVER: begin
               if (cnt == LAST) begin
                  state <= PDN_IDLE;
                  cnt   <= '0;
               end else begin
                  state <= PDN_RECOVER;
                  cnt   <= cnt + 1'b1;
               end
            end
            default: begin
               state <= PDN_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/pdn_hold_bank.sv
module pdn_hold_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         freeze,
   input  logic [W-1:0] live,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("pdn_hold_bank: W must be at least 1");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < W; b++) begin : g_bit
         logic held;
         // track the live value every edge until frozen
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       held <= 1'b0;
            else if (!freeze) held <= live[b];
         end
         assign q[b] = freeze ? held : live[b];
      end
   endgenerate

endmodule

// File: rtl/pdn_hold_ctrl.sv
module pdn_hold_ctrl #(
   parameter int unsigned N_DED        = 4,
   parameter int unsigned N_IO         = 8,
   parameter int unsigned PD_IDX       = 7,
   parameter int unsigned RECOV_CYCLES = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_pd_en,
   input  logic             pd_pin,
   input  logic [N_DED-1:0] ded_in,
   input  logic [N_IO-1:0]  pad_in,
   input  logic [N_IO-1:0]  core_out,
   input  logic [N_IO-1:0]  core_oe,
   output logic [N_DED-1:0] ded_q,
   output logic [N_IO-1:0]  io_in_q,
   output logic [N_IO-1:0]  pad_out,
   output logic [N_IO-1:0]  pad_oe,
   output logic             core_ce,
   output logic             pd_active,
   output logic             out_valid
);

   generate
      if (PD_IDX >= N_IO) begin : g_bad_idx
         $error("pdn_hold_ctrl: PD_IDX must address a pad");
      end
   endgenerate

   logic             freeze;
   logic [N_IO-1:0]  io_hold;
   logic [N_IO-1:0]  oe_hold;

   pdn_ctrl #(.RECOV_CYCLES(RECOV_CYCLES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_pd_en (cfg_pd_en),
      .pd_pin    (pd_pin),
      .pd_active (freeze),
      .core_ce   (core_ce),
      .out_valid (out_valid)
   );

   assign pd_active = freeze;

   pdn_hold_bank #(.W(N_DED)) u_ded (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .live(ded_in), .q(ded_q)
   );

   pdn_hold_bank #(.W(N_IO)) u_ioin (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .live(pad_in), .q(io_hold)
   );

   pdn_hold_bank #(.W(N_IO)) u_out (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .live(core_out), .q(pad_out)
   );

   pdn_hold_bank #(.W(N_IO)) u_oe (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .live(core_oe), .q(oe_hold)
   );

   // the pad carrying the request leaves the logic array when armed
   genvar i;
   generate
      for (i = 0; i < N_IO; i++) begin : g_pad
         if (i == PD_IDX) begin : g_pd
            assign io_in_q[i] = cfg_pd_en ? 1'b0 : io_hold[i];
            assign pad_oe[i]  = cfg_pd_en ? 1'b0 : oe_hold[i];
         end else begin : g_norm
            assign io_in_q[i] = io_hold[i];
            assign pad_oe[i]  = oe_hold[i];
         end
      end
   endgenerate

endmodule

// File: rtl/pdn_hold_checker.sv
module pdn_hold_checker #(
   parameter int unsigned N_DED  = 4,
   parameter int unsigned N_IO   = 8,
   parameter int unsigned PD_IDX = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_pd_en,
   input logic             pd_active,
   input logic             core_ce,
   input logic             out_valid,
   input logic [N_DED-1:0] ded_in,
   input logic [N_DED-1:0] ded_q,
   input logic [N_IO-1:0]  pad_in,
   input logic [N_IO-1:0]  io_in_q,
   input logic [N_IO-1:0]  core_out,
   input logic [N_IO-1:0]  pad_out,
   input logic [N_IO-1:0]  pad_oe
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2: register clocking stops whenever power-down holds
   assert_ce_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pd_active |-> !core_ce);

   // R3: disarmed feature is transparent
   assert_transparent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_pd_en |-> (io_in_q == pad_in) && (ded_q == ded_in) && (pad_out == core_out));

   // R4: logic-side inputs frozen
   assert_inputs_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(pd_active) && pd_active) |-> ($stable(ded_q) && $stable(io_in_q)));

   // R5: pad-side outputs and enables frozen
   assert_outputs_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(pd_active) && pd_active) |-> ($stable(pad_out) && $stable(pad_oe)));

   // R7: request pad never drives and never feeds the logic when armed
   assert_pd_pad_removed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_pd_en |-> (!pad_oe[PD_IDX] && !io_in_q[PD_IDX]));

   // R8: status low during power-down and on the first edge after it
   assert_valid_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_active || (past_ok && $past(pd_active))) |-> !out_valid);

endmodule

bind pdn_hold_ctrl pdn_hold_checker #(
   .N_DED(N_DED), .N_IO(N_IO), .PD_IDX(PD_IDX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_pd_en (cfg_pd_en),
   .pd_active (pd_active),
   .core_ce   (core_ce),
   .out_valid (out_valid),
   .ded_in    (ded_in),
   .ded_q     (ded_q),
   .pad_in    (pad_in),
   .io_in_q   (io_in_q),
   .core_out  (core_out),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe)
);

// File: tb/tb_pdn_hold_ctrl.sv
module tb_pdn_hold_ctrl;
   localparam int ND = 4;
   localparam int NI = 8;
   localparam int PI = 7;
   localparam int RC = 5;
   localparam logic [NI-1:0] PDM = NI'(1) << PI;

   logic clk = 1'b0;
   logic rst_n, cfg_pd_en, pd_pin;
   logic [ND-1:0] ded_in, ded_q;
   logic [NI-1:0] pad_in, core_out, core_oe, io_in_q, pad_out, pad_oe;
   logic core_ce, pd_active, out_valid;

   int vectors = 0;
   int miscmp  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   pdn_hold_ctrl #(.N_DED(ND), .N_IO(NI), .PD_IDX(PI), .RECOV_CYCLES(RC)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_pd_en(cfg_pd_en), .pd_pin(pd_pin),
      .ded_in(ded_in), .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
      .ded_q(ded_q), .io_in_q(io_in_q), .pad_out(pad_out), .pad_oe(pad_oe),
      .core_ce(core_ce), .pd_active(pd_active), .out_valid(out_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscmp++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edge1();
      @(posedge clk);
      #1;
   endtask

   task automatic drive(input logic [ND-1:0] d, input logic [NI-1:0] pi,
                        input logic [NI-1:0] co, input logic [NI-1:0] oe);
      ded_in = d; pad_in = pi; core_out = co; core_oe = oe;
   endtask

   initial begin
      #100000;
      if (!done) begin
         miscmp++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
         $finish;
      end
   end

   initial begin
      logic [ND-1:0] ad;
      logic [NI-1:0] ap, ao, ae;
      rst_n = 1'b0; cfg_pd_en = 1'b0; pd_pin = 1'b0;
      drive('0, '0, '0, '0);
      #1;
      chk("R1 pd_active in reset", 32'(pd_active), 0);
      chk("R1 core_ce in reset",   32'(core_ce), 1);
      chk("R1 out_valid in reset", 32'(out_valid), 1);
      edge1(); edge1();
      rst_n = 1'b1;
      edge1();
      chk("R1 out_valid after reset", 32'(out_valid), 1);
      chk("R1 core_ce after reset",   32'(core_ce), 1);

      // R3 sweep: feature disarmed, request toggling
      for (int k = 0; k < 64; k++) begin
         drive(ND'(k * 3 + 1), NI'(k * 37 + 5), NI'(k * 53 + 11), NI'(k * 29 + 200));
         pd_pin = k[0];
         #1;
         chk("R3 ded_q",   32'(ded_q),   32'(ded_in));
         chk("R3 io_in_q", 32'(io_in_q), 32'(pad_in));
         chk("R3 pad_out", 32'(pad_out), 32'(core_out));
         chk("R3 pad_oe",  32'(pad_oe),  32'(core_oe));
         chk("R2 pd_active disarmed", 32'(pd_active), 0);
         edge1();
      end
      pd_pin = 1'b0;
      edge1();
      cfg_pd_en = 1'b1;

      // hold sweep with feature armed
      for (int k = 0; k < 16; k++) begin
         ad = ND'(k);
         ap = NI'(k * 71 + 3);
         ao = NI'(k * 97 + 40);
         ae = NI'(k * 45 + 90);
         drive(ad, ap, ao, ae);
         #1;
         chk("R7 armed io_in_q live",  32'(io_in_q), 32'(ap & ~PDM));
         chk("R7 armed pad_oe live",   32'(pad_oe),  32'(ae & ~PDM));
         edge1();
         pd_pin = 1'b1;
         #1;
         chk("R2 pd_active", 32'(pd_active), 1);
         chk("R2 core_ce",   32'(core_ce), 0);
         chk("R8 out_valid down", 32'(out_valid), 0);
         for (int j = 0; j < 4; j++) begin
            drive(~ad ^ ND'(j), ~ap ^ NI'(j), ~ao ^ NI'(j), ~ae | NI'(j));
            #1;
            chk("R4 ded_q held",   32'(ded_q),   32'(ad));
            chk("R4 io_in_q held", 32'(io_in_q), 32'(ap & ~PDM));
            chk("R5 pad_out held", 32'(pad_out), 32'(ao));
            chk("R5 pad_oe held",  32'(pad_oe),  32'(ae & ~PDM));
            chk("R6 hi-Z stays",   32'(pad_oe & ~ae), 0);
            chk("R7 pd pad off",   32'({pad_oe[PI], io_in_q[PI]}), 0);
            edge1();
         end
         pd_pin = 1'b0;
         #1;
         chk("R4 live after release", 32'(ded_q), 32'(ded_in));
         chk("R5 live after release", 32'(pad_out), 32'(core_out));
         chk("R8 out_valid at release", 32'(out_valid), 0);
         for (int e = 1; e <= RC; e++) begin
            edge1();
            chk("R8 recovery window", 32'(out_valid), 32'(e == RC));
         end
      end

      // R9: re-entry during recovery restarts the count
      pd_pin = 1'b1;
      edge1();
      pd_pin = 1'b0;
      edge1(); edge1();
      chk("R9 mid-recovery low", 32'(out_valid), 0);
      pd_pin = 1'b1;
      #1;
      chk("R9 re-entered", 32'(out_valid), 0);
      edge1();
      pd_pin = 1'b0;
      for (int e = 1; e <= RC; e++) begin
         edge1();
         chk("R9 restarted window", 32'(out_valid), 32'(e == RC));
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end
endmodule